// File: doc/BRIEF.md
# Decode-Stage Exception Gate

This block sits at the decode stage of a pipeline whose execution units are never allowed to fault. Every instruction that reaches decode is screened here against every condition that could cause an exception. It then leaves decode in one of three ways: it is issued unchanged, it is issued as a substitute operation, or it is turned into a trap request carrying a cause code. An instruction that cannot yet be decided is held with a stall.

Fetch faults arrive already marked on the instruction. Division is screened with one zero-property bit per register. A divide by a register known to hold zero traps. A divide of a known-zero dividend is rewritten as a clear of the destination. Load and store instructions wait for an external pointer-check answer. Floating-point instructions that demand strict results wait until the result is reported safe. Older instructions already issued are never flushed. Once a trap is raised, decode stays blocked until the trap is acknowledged.

Top module: `decode_gate`

## Requirements
- R1: After reset, `issue_valid` and `trap_valid` are 0, `trap_cause` is 0 and `ptr_req_valid` is 0.
- R2: An instruction with `in_fetch_fault` set is taken as a trap with cause 1, whatever its opcode, and never requests a pointer check.
- R3: Opcodes 7 to 15 are invalid and trap with cause 2. They are never issued.
- R4: Opcode 5 (privileged) traps with cause 3 when `user_mode` is 1. When `user_mode` is 0 it is issued unchanged.
- R5: Opcode 6 (explicit trap) traps with cause 4.
- R6: Opcode 1 (divide) traps with cause 5 when `zero_bits[in_rs2]` is set.
- R7: A divide whose `zero_bits[in_rs1]` is set and whose `zero_bits[in_rs2]` is clear is issued with `issue_clear` = 1 and the same destination register.
- R8: Opcode 0 (integer ALU, overflow included) never traps. It is issued one cycle after it is accepted.
- R9: Opcode 4 (floating point) with `in_fp_strict` set stalls while `fp_safe` is 0. It issues once `fp_safe` is 1.
- R10: Opcodes 2 and 3 (load, store) drive `ptr_req_valid` and stall until `ptr_rsp_valid`. An ok answer (`ptr_rsp_fault` = 0) issues the instruction. A fault answer traps with cause 6.
- R11: When several causes apply at once, the one reported is the first in this list: fetch fault, invalid, privileged, trap instruction, divide by zero, address fault.
- R12: While `trap_valid` is 1, no instruction is accepted (`stall` follows `in_valid`) and `trap_cause` holds its value. `trap_ack` clears the trap at the next edge.
- R13: An instruction is consumed when `in_valid` is 1 and `stall` is 0. Each consumed instruction produces exactly one issue or one trap, in the following cycle, and never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 4 | Opcode class |
| in_fetch_fault | input | 1 | Instruction replaced because its fetch faulted |
| in_rd | input | RW | Destination register |
| in_rs1 | input | RW | First source (dividend) |
| in_rs2 | input | RW | Second source (divisor) |
| in_fp_strict | input | 1 | Floating-point strict-result flag |
| user_mode | input | 1 | 1 = user privilege |
| zero_bits | input | NREG | Per-register zero property |
| fp_safe | input | 1 | Floating-point result known safe |
| ptr_rsp_valid | input | 1 | Pointer-check answer present |
| ptr_rsp_fault | input | 1 | Pointer-check answer is a fault |
| trap_ack | input | 1 | Trap taken by the handler |
| stall | output | 1 | Instruction held at decode |
| ptr_req_valid | output | 1 | Pointer check requested |
| issue_valid | output | 1 | Instruction issued this cycle |
| issue_op | output | 4 | Issued opcode |
| issue_rd | output | RW | Issued destination register |
| issue_clear | output | 1 | Issued as a clear of `issue_rd` |
| trap_valid | output | 1 | Trap pending |
| trap_cause | output | 3 | Cause code, 0 when no trap |

## Verification
The hardest situations to reach are the ones where an instruction sits at decode across several cycles while its inputs keep changing. Examples are a load held for a late pointer answer, or an instruction that meets a pending trap and must stay stalled through the acknowledge. Directed sequences hold one instruction on the inputs and change only the answer or acknowledge lines from cycle to cycle. A long random phase then draws zero bits, answer lines and acknowledges every cycle, so that stalls, overlapping causes and traps that arrive back to back occur many times.

// File: rtl/dg_pkg.sv
// Shared encodings for the decode-stage exception gate.
// Assumes 4-bit opcode classes; codes at or above OP_FIRST_BAD are invalid.
package dg_pkg;
    localparam int OPW    = 4;
    localparam int CAUSEW = 3;
    localparam int NCAUSE = 6;

    localparam logic [OPW-1:0] OP_ALU       = 4'd0;
    localparam logic [OPW-1:0] OP_DIV       = 4'd1;
    localparam logic [OPW-1:0] OP_LOAD      = 4'd2;
    localparam logic [OPW-1:0] OP_STORE     = 4'd3;
    localparam logic [OPW-1:0] OP_FP        = 4'd4;
    localparam logic [OPW-1:0] OP_PRIV      = 4'd5;
    localparam logic [OPW-1:0] OP_TRAP      = 4'd6;
    localparam logic [OPW-1:0] OP_FIRST_BAD = 4'd7;

    typedef enum logic [CAUSEW-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_FETCH   = 3'd1,
        CAUSE_INVALID = 3'd2,
        CAUSE_PRIV    = 3'd3,
        CAUSE_TRAPI   = 3'd4,
        CAUSE_DIVZ    = 3'd5,
        CAUSE_ADDR    = 3'd6
    } cause_e;
endpackage

// File: rtl/dg_classify.sv
// Classifies the instruction at decode: raw cause flags (bit k = cause code k),
// memory/floating-point hold conditions and the divide-to-clear rewrite.
// Assumes zero_bits is current for the cycle the instruction is presented.
module dg_classify
    import dg_pkg::*;
#(
    parameter int NREG = 16,
    localparam int RW = $clog2(NREG)
) (
    input  logic [OPW-1:0]  op,
    input  logic            fetch_fault,
    input  logic            user_mode,
    input  logic [RW-1:0]   rs1,
    input  logic [RW-1:0]   rs2,
    input  logic [NREG-1:0] zero_bits,
    input  logic            fp_strict,
    input  logic            fp_safe,
    input  logic            rsp_valid,
    input  logic            rsp_fault,
    output logic [NCAUSE:1] raw,
    output logic            is_mem,
    output logic            fp_hold,
    output logic            do_clear
);
    logic dividend_zero;
    logic divisor_zero;

    // Look up zero properties of both sources.
    always_comb begin
        dividend_zero = zero_bits[rs1];
        divisor_zero  = zero_bits[rs2];
    end

    // Raise one flag per possible cause; priority is resolved elsewhere.
    always_comb begin
        is_mem           = (op == OP_LOAD) || (op == OP_STORE);
        raw[CAUSE_FETCH] = fetch_fault;
        raw[CAUSE_INVALID] = (op >= OP_FIRST_BAD);
        raw[CAUSE_PRIV]  = (op == OP_PRIV) && user_mode;
        raw[CAUSE_TRAPI] = (op == OP_TRAP);
        raw[CAUSE_DIVZ]  = (op == OP_DIV) && divisor_zero;
        raw[CAUSE_ADDR]  = is_mem && rsp_valid && rsp_fault;
    end

    // Hold and rewrite conditions for instructions that do not trap.
    always_comb begin
        fp_hold  = (op == OP_FP) && fp_strict && !fp_safe;
        do_clear = (op == OP_DIV) && dividend_zero && !divisor_zero;
    end
endmodule

// File: rtl/dg_cause_pick.sv
// Fixed-priority selection of one cause code from the raw flags:
// the lowest code wins. Also reports whether any pre-address cause is set.
module dg_cause_pick
    import dg_pkg::*;
(
    input  logic [NCAUSE:1]    raw,
    output logic [CAUSEW-1:0]  cause,
    output logic               any_cause,
    output logic               early_cause
);
    // Scan from lowest priority to highest so the highest one is kept.
    always_comb begin
        cause = CAUSE_NONE;
        for (int k = NCAUSE; k >= 1; k--) begin
            if (raw[k]) cause = CAUSE_NONE + CAUSEW'(k);
        end
    end

    // Summary flags used by the hold logic.
    always_comb begin
        any_cause   = |raw;
        early_cause = |raw[NCAUSE-1:1];
    end
endmodule

// File: rtl/dg_ctl.sv
// Output registers: issue slot, trap-pending flag and latched cause.
// Assumes accept is never asserted while a trap is pending.
module dg_ctl
    import dg_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_issue,
    input  logic              take_trap,
    input  logic [CAUSEW-1:0] cause_in,
    input  logic [OPW-1:0]    op_in,
    input  logic [RW-1:0]     rd_in,
    input  logic              clear_in,
    input  logic              trap_ack,
    output logic              pending,
    output logic [CAUSEW-1:0] cause_q,
    output logic              iss_v,
    output logic [OPW-1:0]    iss_op,
    output logic [RW-1:0]     iss_rd,
    output logic              iss_clr
);
    // Trap-pending state: set on a trap, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (take_trap) begin
            pending <= 1'b1;
            cause_q <= cause_in;
        end else if (pending && trap_ack) begin
            pending <= 1'b0;
            cause_q <= CAUSE_NONE;
        end
    end

    // Issue slot: one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_v   <= 1'b0;
            iss_op  <= '0;
            iss_rd  <= '0;
            iss_clr <= 1'b0;
        end else begin
            iss_v   <= take_issue;
            iss_op  <= take_issue ? op_in : '0;
            iss_rd  <= take_issue ? rd_in : '0;
            iss_clr <= take_issue && clear_in;
        end
    end
endmodule

// File: rtl/decode_gate.sv
// Decode-stage exception gate: screens each instruction for every possible
// exception so that nothing faulting reaches execution. Assumes the pointer
// check answers combinationally or later through ptr_rsp_valid, and that
// the instruction inputs are held while stall is high.
module decode_gate
    import dg_pkg::*;
#(
    parameter int NREG = 16,
    localparam int RW = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPW-1:0]    in_op,
    input  logic              in_fetch_fault,
    input  logic [RW-1:0]     in_rd,
    input  logic [RW-1:0]     in_rs1,
    input  logic [RW-1:0]     in_rs2,
    input  logic              in_fp_strict,
    input  logic              user_mode,
    input  logic [NREG-1:0]   zero_bits,
    input  logic              fp_safe,
    input  logic              ptr_rsp_valid,
    input  logic              ptr_rsp_fault,
    input  logic              trap_ack,
    output logic              stall,
    output logic              ptr_req_valid,
    output logic              issue_valid,
    output logic [OPW-1:0]    issue_op,
    output logic [RW-1:0]     issue_rd,
    output logic              issue_clear,
    output logic              trap_valid,
    output logic [CAUSEW-1:0] trap_cause
);
    logic [NCAUSE:1]    raw;
    logic               is_mem, fp_hold, do_clear;
    logic [CAUSEW-1:0]  cause;
    logic               any_cause, early_cause;
    logic               pending;
    logic               hold, accept, take_trap, take_issue;

    dg_classify #(.NREG(NREG)) u_cls (
        .op(in_op), .fetch_fault(in_fetch_fault), .user_mode(user_mode),
        .rs1(in_rs1), .rs2(in_rs2), .zero_bits(zero_bits),
        .fp_strict(in_fp_strict), .fp_safe(fp_safe),
        .rsp_valid(ptr_rsp_valid), .rsp_fault(ptr_rsp_fault),
        .raw(raw), .is_mem(is_mem), .fp_hold(fp_hold), .do_clear(do_clear)
    );

    dg_cause_pick u_pick (
        .raw(raw), .cause(cause), .any_cause(any_cause), .early_cause(early_cause)
    );

    // Decide whether the instruction must wait at decode this cycle.
    always_comb begin
        hold       = !early_cause && ((is_mem && !ptr_rsp_valid) || fp_hold);
        accept     = in_valid && !pending && !hold;
        take_trap  = accept && any_cause;
        take_issue = accept && !any_cause;
    end

    // Handshake outputs towards fetch and the pointer checker.
    always_comb begin
        stall         = in_valid && !accept;
        ptr_req_valid = in_valid && !pending && is_mem && !early_cause;
    end

    dg_ctl #(.RW(RW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .take_issue(take_issue), .take_trap(take_trap), .cause_in(cause),
        .op_in(in_op), .rd_in(in_rd), .clear_in(do_clear), .trap_ack(trap_ack),
        .pending(pending), .cause_q(trap_cause),
        .iss_v(issue_valid), .iss_op(issue_op), .iss_rd(issue_rd), .iss_clr(issue_clear)
    );

    // Trap-pending flag is the trap request.
    always_comb trap_valid = pending;
endmodule

// File: rtl/dg_checker.sv
// Property checker for decode_gate, attached by bind below.
module dg_checker
    import dg_pkg::*;
#(
    parameter int NREG = 16,
    localparam int RW = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPW-1:0]    in_op,
    input logic              in_fetch_fault,
    input logic              in_fp_strict,
    input logic              fp_safe,
    input logic              ptr_rsp_valid,
    input logic              trap_ack,
    input logic              stall,
    input logic              ptr_req_valid,
    input logic              issue_valid,
    input logic              issue_clear,
    input logic              trap_valid,
    input logic [CAUSEW-1:0] trap_cause
);
    assert_idle_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> trap_cause == CAUSE_NONE);

    assert_fetch_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch_fault |-> !ptr_req_valid);

    assert_clear_is_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_clear |-> issue_valid);

    assert_fp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op == OP_FP && in_fp_strict && !fp_safe && !in_fetch_fault |-> stall);

    assert_mem_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req_valid && !ptr_rsp_valid |-> stall);

    assert_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && in_valid |-> stall);

    assert_cause_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_ack |=> trap_valid && $stable(trap_cause));

    assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && trap_valid) || $past(trap_valid));
endmodule

bind decode_gate dg_checker #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_fetch_fault(in_fetch_fault), .in_fp_strict(in_fp_strict), .fp_safe(fp_safe),
    .ptr_rsp_valid(ptr_rsp_valid), .trap_ack(trap_ack), .stall(stall),
    .ptr_req_valid(ptr_req_valid), .issue_valid(issue_valid), .issue_clear(issue_clear),
    .trap_valid(trap_valid), .trap_cause(trap_cause)
);

// File: tb/tb_decode_gate.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module tb_decode_gate;
    localparam int NREG = 16;
    localparam int RW = $clog2(NREG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_fetch_fault = 0, in_fp_strict = 0, user_mode = 0;
    logic [3:0] in_op = 0;
    logic [RW-1:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0;
    logic [NREG-1:0] zero_bits = 0;
    logic fp_safe = 0, ptr_rsp_valid = 0, ptr_rsp_fault = 0, trap_ack = 0;
    logic stall, ptr_req_valid, issue_valid, issue_clear, trap_valid;
    logic [3:0] issue_op;
    logic [RW-1:0] issue_rd;
    logic [2:0] trap_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit m_pend = 0;
    int m_cause = 0;
    bit m_iv = 0, m_clr = 0;
    int m_op = 0, m_rd = 0;

    always #2.5 clk = ~clk;

    decode_gate #(.NREG(NREG)) dut (.*);

    task automatic chk(string tag, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // One clock: check combinational outputs, advance model, check registers.
    task automatic cyc(string tag);
        int cz;
        bit mem, early, waitx, acc, clr;
        #1;
        cz = 0;
        mem = (in_op == 2) || (in_op == 3);
        if (in_fetch_fault) cz = 1;
        else if (in_op >= 7) cz = 2;
        else if (in_op == 5 && user_mode) cz = 3;
        else if (in_op == 6) cz = 4;
        else if (in_op == 1 && zero_bits[in_rs2]) cz = 5;
        early = (cz != 0);
        if (!early && mem && ptr_rsp_valid && ptr_rsp_fault) cz = 6;
        waitx = !early && ((mem && !ptr_rsp_valid) ||
                           (in_op == 4 && in_fp_strict && !fp_safe));
        acc = in_valid && !m_pend && !waitx;
        clr = (in_op == 1) && zero_bits[in_rs1] && !zero_bits[in_rs2];
        chk(tag, stall, in_valid && !acc, "stall");
        chk(tag, ptr_req_valid, in_valid && !m_pend && mem && !early, "ptr_req_valid");
        @(posedge clk);
        if (acc && cz != 0) begin m_pend = 1; m_cause = cz; end
        else if (m_pend && trap_ack) begin m_pend = 0; m_cause = 0; end
        m_iv = acc && cz == 0;
        m_op = m_iv ? int'(in_op) : 0;
        m_rd = m_iv ? int'(in_rd) : 0;
        m_clr = m_iv && clr;
        @(negedge clk);
        chk(tag, trap_valid, m_pend, "trap_valid");
        chk(tag, trap_cause, m_cause, "trap_cause");
        chk(tag, issue_valid, m_iv, "issue_valid");
        chk(tag, issue_op, m_op, "issue_op");
        chk(tag, issue_rd, m_rd, "issue_rd");
        chk(tag, issue_clear, m_clr, "issue_clear");
    endtask

    task automatic put(bit v, bit ff, int op, int rd, int rs1, int rs2);
        in_valid = v; in_fetch_fault = ff; in_op = 4'(op);
        in_rd = RW'(rd); in_rs1 = RW'(rs1); in_rs2 = RW'(rs2);
    endtask

    // Acknowledge a pending trap while a new instruction waits (R12).
    task automatic drain(string tag);
        put(1, 0, 0, 2, 0, 0);
        cyc(tag); cyc(tag);
        trap_ack = 1; cyc(tag); trap_ack = 0;
        put(0, 0, 0, 0, 0, 0); cyc(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cyc("R1");
        // R8: plain ALU issues next cycle
        put(1, 0, 0, 3, 1, 2); cyc("R8");
        put(0, 0, 0, 0, 0, 0); cyc("R8");
        // R2/R11: fetch fault on a load beats everything, no pointer request
        put(1, 1, 2, 1, 0, 0); cyc("R2"); drain("R12");
        // R3: invalid opcodes
        put(1, 0, 9, 1, 0, 0); cyc("R3"); drain("R3");
        put(1, 0, 7, 1, 0, 0); cyc("R3"); drain("R3");
        // R4: privileged in user and supervisor mode
        user_mode = 1; put(1, 0, 5, 4, 0, 0); cyc("R4"); drain("R4");
        user_mode = 0; put(1, 0, 5, 4, 0, 0); cyc("R4");
        // R5: trap instruction
        put(1, 0, 6, 0, 0, 0); cyc("R5"); drain("R5");
        // R6/R7: divide screening
        zero_bits = 16'h0006;
        put(1, 0, 1, 5, 3, 2); cyc("R6"); drain("R6");
        put(1, 0, 1, 5, 1, 3); cyc("R7");
        put(1, 0, 1, 6, 1, 2); cyc("R11"); drain("R11");
        put(1, 0, 1, 7, 3, 4); cyc("R7");
        // R11: invalid beats privileged-in-user via fetch? fetch beats trap instr
        put(1, 1, 6, 0, 0, 0); cyc("R11"); drain("R11");
        // R9: strict floating point waits for safe
        in_fp_strict = 1; fp_safe = 0;
        put(1, 0, 4, 8, 0, 0); cyc("R9"); cyc("R9"); cyc("R9");
        fp_safe = 1; cyc("R9"); in_fp_strict = 0;
        // R10: load waits for answer, ok issues
        put(1, 0, 2, 9, 0, 0); cyc("R10"); cyc("R10");
        ptr_rsp_valid = 1; ptr_rsp_fault = 0; cyc("R10");
        // R10: store with fault answer
        ptr_rsp_fault = 1; put(1, 0, 3, 9, 0, 0); cyc("R10");
        ptr_rsp_valid = 0; ptr_rsp_fault = 0; drain("R10");
        // R12: ack without pending trap is ignored
        trap_ack = 1; put(1, 0, 0, 11, 0, 0); cyc("R12"); trap_ack = 0;
        // R13: random mix
        for (int i = 0; i < 3000; i++) begin
            put($urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0,
                $urandom_range(0, 9), $urandom_range(0, NREG - 1),
                $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1));
            user_mode = $urandom_range(0, 1);
            zero_bits = NREG'($urandom);
            in_fp_strict = $urandom_range(0, 1);
            fp_safe = $urandom_range(0, 2) == 0;
            ptr_rsp_valid = $urandom_range(0, 2) == 0;
            ptr_rsp_fault = $urandom_range(0, 1);
            trap_ack = $urandom_range(0, 3) == 0;
            cyc("R13");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule